// File: doc/BRIEF.md
# Two-Stage Timer Clock Prescaler

This block turns one of several slow timer clock sources into a single-cycle tick enable for a timer counter. All logic runs on one fast clock. The chosen source is sampled as a level, and each of its rising transitions counts as one input event. Two down-counting stages are chained. The first divides the events by a power of two. The second divides the first stage's output by any ratio from one to eight. The counter that consumes the tick advances once per overall period.

A clear input reloads both stages to a known phase. The divide-ratio inputs are left alone, so the first tick after clear falls on a fixed source edge. If the ratio inputs change while the block is running, each stage takes the new value the next time it reloads. No clear is needed for that.

Top module: `tick_prescaler`

## Requirements
- R1: While reset is asserted (rst_n low), tick is 0, and it stays 0 until a qualifying source edge has been counted.
- R2: src_sel value i selects src_in[i] as the source. Rising transitions on any other src_in bit leave the divider phase and the tick unchanged.
- R3: The first stage divides source rising edges by 2^pre_sel (pre_sel 0..3 gives 1, 2, 4, 8).
- R4: The second stage divides first-stage events by div_sel+1 (div_sel 0..7 gives 1..8). The overall tick period is the product of both ratios in source rising edges, up to 64.
- R5: tick is high for exactly one fast-clock cycle, in the cycle after the fast-clock edge that samples the qualifying source rise. A source held high yields at most one event.
- R6: clr reloads the first stage with 2^pre_sel-1 and the second with div_sel. Source edges seen while clr is high are ignored and tick is held 0. After release, the first tick falls on the (product)-th source rising edge.
- R7: A change of pre_sel or div_sel without clr takes effect when the affected stage next reloads on reaching zero. The count already in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NSRC | Candidate timer clock sources, sampled as levels |
| src_sel | input | $clog2(NSRC) | Index of the active source |
| pre_sel | input | PRE_W | First-stage ratio code, divide by 2^code |
| div_sel | input | DIV_W | Second-stage ratio code, divide by code+1 |
| clr | input | 1 | Reload both stages, suppress tick |
| tick | output | 1 | One-cycle enable per divided period |

## Verification
The bench builds the block with its defaults: four sources, a 2-bit first-stage code and a 3-bit second-stage code. This brings the full ratio range from 1 up to 64 within reach, along with every source index. Ratio pairs 1x1, 2x3, 4x5 and 8x8 are swept for many periods. Clear is applied both mid-count and while a source edge is pending. The second-stage code is also changed partway through a count, so the deferred reload can be observed at the tick output.

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int NSRC  = 4,
  parameter int PRE_W = 2,
  parameter int DIV_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_in,
  input  logic [$clog2(NSRC)-1:0] src_sel,
  input  logic [PRE_W-1:0]        pre_sel,
  input  logic [DIV_W-1:0]        div_sel,
  input  logic                    clr,
  output logic                    tick
);
  localparam int C1 = (1 << PRE_W) - 1;

  logic          src_cur, src_prev, src_rise;
  logic [C1-1:0] s1_cnt, pre_m1;
  logic [DIV_W-1:0] s2_cnt;
  logic          s1_fire, s2_fire;

  assign src_cur  = src_in[src_sel];
  assign src_rise = src_cur & ~src_prev;
  assign pre_m1   = C1'((32'd1 << pre_sel) - 32'd1);
  assign s1_fire  = src_rise & (s1_cnt == '0);
  assign s2_fire  = s1_fire & (s2_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_prev <= 1'b1;
    else        src_prev <= src_cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        s1_cnt <= '0;
    else if (clr)      s1_cnt <= pre_m1;
    else if (src_rise) s1_cnt <= (s1_cnt == '0) ? pre_m1 : s1_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       s2_cnt <= '0;
    else if (clr)     s2_cnt <= div_sel;
    else if (s1_fire) s2_cnt <= (s2_cnt == '0) ? div_sel : s2_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= s2_fire & ~clr;
endmodule

// File: rtl/tick_prescaler_chk.sv
module tick_prescaler_chk #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       tick,
  input logic                       src_rise,
  input logic [(1<<PRE_W)-2:0]      s1_cnt,
  input logic [(1<<PRE_W)-2:0]      pre_m1,
  input logic [DIV_W-1:0]           s2_cnt,
  input logic [DIV_W-1:0]           div_sel
);
  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R6
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !tick);
  // R6
  clr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s1_cnt == $past(pre_m1)) && (s2_cnt == $past(div_sel)));
  // R4
  tick_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(s1_cnt == '0 && s2_cnt == '0 && src_rise));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !src_rise) |=> $stable(s1_cnt) && $stable(s2_cnt));
endmodule

bind tick_prescaler tick_prescaler_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .src_rise(src_rise),
  .s1_cnt(s1_cnt), .pre_m1(pre_m1), .s2_cnt(s2_cnt), .div_sel(div_sel)
);

// File: tb/tick_prescaler_bench.sv
module tick_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_in = '0;
  logic [1:0] src_sel = '0;
  logic [1:0] pre_sel = '0;
  logic [2:0] div_sel = '0;
  logic       clr = 1'b0;
  logic       tick;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  tick_prescaler u_tick_prescaler (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_sel(src_sel),
    .pre_sel(pre_sel), .div_sel(div_sel), .clr(clr), .tick(tick)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: tick=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int idx, output logic seen);
    src_in[idx] = 1'b1;
    @(negedge clk); seen = tick;
    src_in[idx] = 1'b0;
    @(negedge clk);
    check("R5 after pulse", tick, 1'b0);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", tick, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", tick, 1'b0);
  endtask

  task automatic t_ratio(input int p, input int d);
    int r = (1 << p) * (d + 1);
    logic seen;
    src_sel = 2'd0; pre_sel = 2'(p); div_sel = 3'(d);
    do_clear();
    for (int k = 1; k <= 2 * r + 1; k++) begin
      pulse(0, seen);
      check($sformatf("R3 R4 ratio %0d pulse %0d", r, k), seen, (k % r) == 0);
    end
  endtask

  task automatic t_select();
    logic seen;
    src_sel = 2'd2; pre_sel = 2'd1; div_sel = 3'd0;
    do_clear();
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 4; i++)
        if (i != 2) begin pulse(i, seen); check("R2 other source", seen, 1'b0); end
    pulse(2, seen); check("R2 first selected", seen, 1'b0);
    pulse(2, seen); check("R2 second selected", seen, 1'b1);
    src_sel = 2'd3;
    pulse(2, seen); check("R2 deselected", seen, 1'b0);
    pulse(3, seen); check("R2 new source", seen, 1'b0);
    pulse(3, seen); check("R2 new source tick", seen, 1'b1);
  endtask

  task automatic t_hold_high();
    int cnt = 0;
    src_sel = 2'd1; pre_sel = 2'd0; div_sel = 3'd0;
    do_clear();
    src_in[1] = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    src_in[1] = 1'b0;
    @(negedge clk);
    check("R5 held level single tick", cnt == 1, 1'b1);
  endtask

  task automatic t_clear_mid();
    logic seen;
    src_sel = 2'd0; pre_sel = 2'd1; div_sel = 3'd2;
    do_clear();
    for (int k = 0; k < 4; k++) pulse(0, seen);
    @(negedge clk); clr = 1'b1; src_in[0] = 1'b1;
    @(negedge clk);
    check("R6 tick low during clr", tick, 1'b0);
    clr = 1'b0; src_in[0] = 1'b0;
    @(negedge clk);
    for (int k = 1; k <= 6; k++) begin
      pulse(0, seen);
      check($sformatf("R6 after clr pulse %0d", k), seen, k == 6);
    end
  endtask

  task automatic t_ratio_change();
    logic seen;
    src_sel = 2'd0; pre_sel = 2'd0; div_sel = 3'd3;
    do_clear();
    pulse(0, seen); pulse(0, seen);
    div_sel = 3'd1;
    for (int k = 3; k <= 8; k++) begin
      pulse(0, seen);
      check($sformatf("R7 deferred reload pulse %0d", k), seen, (k % 2) == 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(0, 0);
    t_ratio(1, 2);
    t_ratio(2, 4);
    t_ratio(3, 7);
    t_select();
    t_hold_high();
    t_clear_mid();
    t_ratio_change();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule